// File: doc/BRIEF.md
# Reference Divider With Selectable Binary Taps

This block divides a reference clock by a programmable integer R and then halves that result four more times. The outcome is five candidate pulse streams, with periods of R, 2R, 4R, 8R and 16R reference cycles. Two independent 3-bit select words each route one of these taps to an output. One output feeds the main phase detector. The other feeds the auxiliary phase detector. Every output pulse lasts exactly one reference clock cycle.

The first stage is a small state machine with two states.
- `PS_LOAD` is entered on reset. It captures R and always moves to `PS_COUNT` on the next edge. This is the "start" transition.
- `PS_COUNT` increments a counter. When the counter reaches R-1 it raises a terminal-count strobe, clears the counter and captures R again. This is the "wrap" transition, which returns to `PS_COUNT`.
- All other cycles take the "step" transition, which also stays in `PS_COUNT`.

Each binary stage is a toggle bit gated by the tap below it. Each output stage turns its select word into a tap index and registers the selected tap.

The two select words decode in opposite directions. On the main output, code 0 picks the R tap. On the auxiliary output, code 4 picks the R tap.

Top module: `refdiv_taps`

## Requirements
- R1: With tap 0 selected, an output pulses once every R reference cycles, where R is the value on `div_r`.
- R2: `div_r` values from 4 to 1023 are used as given. Values 0 to 3 behave as R = 4.
- R3: Tap k (k = 0..4) pulses every R·2^k cycles. Its first pulse comes on the 2^k-th terminal count of the first stage after reset.
- R4: The main select codes 0, 1, 2, 3 and 4 choose taps 0, 1, 2, 3 and 4 respectively.
- R5: The auxiliary select codes 4, 3, 2, 1 and 0 choose taps 0, 1, 2, 3 and 4 respectively.
- R6: Select codes 5, 6 and 7 choose tap 0 on either output.
- R7: Each output pulse is high for exactly one cycle. It is registered one cycle after the terminal-count cycle. Counting rising edges from the first edge after reset release as edge 1, tap k pulses are visible after edges m·R·2^k + 1, for m ≥ 1.
- R8: A change on `div_r` takes effect only at the next terminal count of the first stage. The period in progress keeps its old length.
- R9: While `rst_n` is low, both outputs are low and all binary stages are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_r | input | 10 | First-stage divide value R |
| sel_main | input | 3 | Tap select for the main output |
| sel_aux | input | 3 | Tap select for the auxiliary output, reverse decode |
| main_pulse | output | 1 | Pulse stream to the main phase detector |
| aux_pulse | output | 1 | Pulse stream to the auxiliary phase detector |

## Verification
The bench sweeps every main code, with a reversed auxiliary code, over several small values of R. It compares each cycle against an edge-index formula, so the following faults would show up:
- An off-by-one terminal count would shift every pulse by one cycle.
- A decode that ignored the reversed auxiliary order would pick the wrong period.
- Reserved codes that fell through to a long tap would be caught.

R values below the minimum and the maximum value are each run, which catches a missing clamp or a truncated counter. A mid-period change of R is timed against the expected pulse positions: a design that reloaded at once would cut the period in progress short.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    typedef enum logic [0:0] {
        PS_LOAD  = 1'b0,
        PS_COUNT = 1'b1
    } ps_state_t;

    // Map a select code onto a tap index; out-of-range codes pick tap 0.
    function automatic int unsigned tap_index(
        input int unsigned code,
        input int unsigned ntap,
        input bit          reverse
    );
        if (code >= ntap)
            return 0;
        else if (reverse)
            return ntap - 1 - code;
        else
            return code;
    endfunction

endpackage

// File: rtl/refdiv_prescale.sv
module refdiv_prescale
    import refdiv_pkg::*;
#(
    parameter int RW   = 10,
    parameter int RMIN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] div_r,
    output logic          tc,
    output logic          reload,
    output logic [RW-1:0] cnt,
    output logic [RW-1:0] r_act
);

    localparam logic [RW-1:0] R_FLOOR = RW'(RMIN);

    ps_state_t     state_q, state_d;
    logic [RW-1:0] r_clamped;
    logic          at_end;

    assign r_clamped = (div_r < R_FLOOR) ? R_FLOOR : div_r;
    assign at_end    = (cnt == r_act - RW'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PS_LOAD;
        else
            state_q <= state_d;
    end

    // Next state and strobes
    always_comb begin
        state_d = state_q;
        tc      = 1'b0;
        reload  = 1'b0;
        unique case (state_q)
            PS_LOAD: begin
                reload  = 1'b1;
                state_d = PS_COUNT;
            end
            PS_COUNT: begin
                if (at_end) begin
                    tc     = 1'b1;
                    reload = 1'b1;
                end
                state_d = PS_COUNT;
            end
        endcase
    end

    // Counter and divide-value holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            r_act <= R_FLOOR;
        end else if (reload) begin
            cnt   <= '0;
            r_act <= r_clamped;
        end else begin
            cnt   <= cnt + RW'(1);
        end
    end

endmodule

// File: rtl/refdiv_binchain.sv
module refdiv_binchain #(
    parameter int NSTAGE = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tc,
    output logic [NSTAGE:0] taps
);

    logic [NSTAGE-1:0] tgl;

    assign taps[0] = tc;

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                tgl[k] <= 1'b0;
            else if (taps[k])
                tgl[k] <= ~tgl[k];
        end
        assign taps[k+1] = taps[k] & tgl[k];
    end

endmodule

// File: rtl/refdiv_tapsel.sv
module refdiv_tapsel
    import refdiv_pkg::*;
#(
    parameter int NTAP    = 5,
    parameter int SELW    = 3,
    parameter bit REVERSE = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NTAP-1:0] taps,
    input  logic [SELW-1:0] sel,
    output logic            pulse
);

    localparam int IW = $clog2(NTAP);

    logic [IW-1:0] idx;

    always_comb begin
        idx = IW'(tap_index(int'(sel), NTAP, REVERSE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pulse <= 1'b0;
        else
            pulse <= taps[idx];
    end

endmodule

// File: rtl/refdiv_taps.sv
module refdiv_taps #(
    parameter int RW     = 10,
    parameter int RMIN   = 4,
    parameter int NSTAGE = 4,
    parameter int SELW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RW-1:0]   div_r,
    input  logic [SELW-1:0] sel_main,
    input  logic [SELW-1:0] sel_aux,
    output logic            main_pulse,
    output logic            aux_pulse
);

    localparam int NTAP = NSTAGE + 1;

    logic            tc;
    logic            reload;
    logic [RW-1:0]   cnt;
    logic [RW-1:0]   r_act;
    logic [NTAP-1:0] taps;

    refdiv_prescale #(.RW(RW), .RMIN(RMIN)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_r  (div_r),
        .tc     (tc),
        .reload (reload),
        .cnt    (cnt),
        .r_act  (r_act)
    );

    refdiv_binchain #(.NSTAGE(NSTAGE)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .tc    (tc),
        .taps  (taps)
    );

    refdiv_tapsel #(.NTAP(NTAP), .SELW(SELW), .REVERSE(1'b0)) u_sel_main (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps),
        .sel   (sel_main),
        .pulse (main_pulse)
    );

    refdiv_tapsel #(.NTAP(NTAP), .SELW(SELW), .REVERSE(1'b1)) u_sel_aux (
        .clk   (clk),
        .rst_n (rst_n),
        .taps  (taps),
        .sel   (sel_aux),
        .pulse (aux_pulse)
    );

endmodule

// File: rtl/refdiv_taps_chk.sv
module refdiv_taps_chk #(
    parameter int RW   = 10,
    parameter int RMIN = 4,
    parameter int SELW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            main_pulse,
    input logic            aux_pulse,
    input logic [SELW-1:0] sel_main,
    input logic [SELW-1:0] sel_aux,
    input logic            tc,
    input logic            reload,
    input logic [RW-1:0]   cnt,
    input logic [RW-1:0]   r_act
);

    // R1: counter never reaches the active divide value
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < r_act);

    // R2: active divide value is never below the floor
    p_rmin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_act >= RW'(RMIN));

    // R4: main code 0 registers the first-stage strobe
    p_main_tap0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_main == '0 && $past(sel_main) == '0) |-> (main_pulse == $past(tc)));

    // R5: aux code 4 registers the first-stage strobe
    p_aux_tap0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_aux == SELW'(4) && $past(sel_aux) == SELW'(4)) |-> (aux_pulse == $past(tc)));

    // R7: pulses are one cycle wide
    p_main_one_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        main_pulse |=> !main_pulse);
    p_aux_one_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        aux_pulse |=> !aux_pulse);

    // R8: divide value changes only on a reload cycle
    p_r_swap_at_tc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_act) |-> $past(reload));

endmodule

bind refdiv_taps refdiv_taps_chk #(.RW(RW), .RMIN(RMIN), .SELW(SELW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .main_pulse (main_pulse),
    .aux_pulse  (aux_pulse),
    .sel_main   (sel_main),
    .sel_aux    (sel_aux),
    .tc         (tc),
    .reload     (reload),
    .cnt        (cnt),
    .r_act      (r_act)
);

// File: tb/refdiv_taps_tb.sv
module refdiv_taps_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] div_r = 10'd4;
    logic [2:0] sel_main = 3'd0;
    logic [2:0] sel_aux = 3'd4;
    logic       main_pulse, aux_pulse;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    refdiv_taps u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_r      (div_r),
        .sel_main   (sel_main),
        .sel_aux    (sel_aux),
        .main_pulse (main_pulse),
        .aux_pulse  (aux_pulse)
    );

    function automatic int main_k(input int code);
        return (code > 4) ? 0 : code;
    endfunction

    function automatic int aux_k(input int code);
        return (code > 4) ? 0 : 4 - code;
    endfunction

    function automatic bit exp_pulse(input int n, input int r, input int k);
        int per;
        per = r << k;
        return (n >= 2) && (((n - 1) % per) == 0);
    endfunction

    task automatic check(input string req, input bit act, input bit exp, input int n);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s edge %0d: actual %0b expected %0b", req, n, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", main_pulse, 1'b0, 0);
        check("R9", aux_pulse, 1'b0, 0);
        rst_n = 1'b1;
    endtask

    // Run one configuration; r_in is driven, r_eff is the expected divide value.
    task automatic run_cfg(input int r_in, input int r_eff, input int m, input int a, input int ncyc);
        string rm, ra;
        @(negedge clk);
        div_r    = 10'(r_in);
        sel_main = 3'(m);
        sel_aux  = 3'(a);
        do_reset();
        rm = (m > 4) ? "R6" : ((r_in < 4) ? "R2" : "R4");
        ra = (a > 4) ? "R6" : ((r_in < 4) ? "R2" : "R5");
        for (int n = 1; n <= ncyc; n++) begin
            @(posedge clk);
            @(negedge clk);
            check(rm, main_pulse, exp_pulse(n, r_eff, main_k(m)), n);
            check(ra, aux_pulse, exp_pulse(n, r_eff, aux_k(a)), n);
        end
    endtask

    initial begin
        int rlist [4] = '{4, 5, 7, 13};
        @(negedge clk);
        // R3, R4, R5, R6, R7: all codes over several R values
        foreach (rlist[i]) begin
            for (int m = 0; m < 8; m++) begin
                run_cfg(rlist[i], rlist[i], m, 7 - m, rlist[i] * 32 + 3);
            end
        end
        // R2: values below the floor act as 4
        run_cfg(0, 4, 1, 3, 4 * 32 + 3);
        run_cfg(3, 4, 4, 0, 4 * 32 + 3);
        // R1, R2: maximum divide value
        run_cfg(1023, 1023, 0, 4, 1023 * 2 + 3);
        // R8: change R mid-period
        @(negedge clk);
        div_r    = 10'd10;
        sel_main = 3'd0;
        sel_aux  = 3'd4;
        do_reset();
        for (int n = 1; n <= 45; n++) begin
            bit e;
            @(posedge clk);
            @(negedge clk);
            if (n == 15) div_r = 10'd6;
            e = (n == 11) || (n == 21) || (n >= 27 && ((n - 21) % 6) == 0);
            check("R8", main_pulse, e, n);
            check("R8", aux_pulse, e, n);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule